// File: doc/BRIEF.md
# Whole-Array Erase and Verify Sequencer

This controller drives a byte-wide electrically erasable memory array through a complete chip erase. The erase has a fixed order. The sequencer first writes zero to every location, so that all cells start from the same charge state. It then repeats two steps. The first is a whole-chip erase pulse, held while a high-voltage flag is raised on the array's ninth address line and on the program supply. The second is a full read-back that expects every bit to be one.

A host raises `start` for one cycle. The sequencer then owns the memory control port until it reports its result. That result is a one-cycle `done` strobe together with a `pass` or `fail` level. The level stays up until the next accepted start. The sequencer produces only the high-voltage enable flags. The supplies behind those flags are generated elsewhere.

All durations are counted in clock cycles and given as parameters. These are the program pulse, the erase pulse and the settle time between erase and verify. The attempt limit is also a parameter, with a default of 200 attempts. A verify pass stops at the first byte that is not all ones, and another erase attempt starts at once.

Top module: `chip_erase_seq`

## Requirements
- R1: While `rst_n` is low and afterwards until `start`, the sequencer holds `mem_ce_n`, `mem_oe_n` and `mem_pgm_n` high, both high-voltage flags low, and `done`, `pass` and `fail` low.
- R2: After `start`, every address from 0 to the last address receives one program pulse in ascending order, before any erase pulse. A program pulse has `mem_pgm_n` low for `PROG_CYC` cycles with `mem_ce_n` low, `mem_oe_n` high, `hv_supply_en` high, `hv_addr_en` low and `mem_wdata` equal to 0x00.
- R3: An erase pulse raises `hv_addr_en` together with `hv_supply_en`, with `mem_pgm_n` low, `mem_ce_n` low and `mem_oe_n` high. It lasts exactly `ERASE_CYC` cycles.
- R4: After each erase pulse, at least `SETUP_CYC` cycles with `hv_addr_en` low and `mem_oe_n` high pass before the first verify read.
- R5: A verify read has `mem_ce_n` and `mem_oe_n` low, `mem_pgm_n` high and `hv_addr_en` low. Each verify pass presents addresses in ascending order, starting at 0.
- R6: A verify pass stops on the first byte whose read data differs from all ones. If fewer than `MAX_TRIES` pulses have been applied, another erase pulse follows. A pass that stops at address k therefore makes k+1 reads.
- R7: When every byte of a verify pass reads all ones, the sequencer raises `done` together with `pass` high and `fail` low.
- R8: If the verify that follows erase pulse number `MAX_TRIES` fails, the sequencer raises `done` together with `fail` high and `pass` low. No further erase pulse is applied.
- R9: A `start` seen while a sequence is running has no effect on that sequence, its pulse count or its result.
- R10: `done` is high for one cycle only. `pass` and `fail` keep their value until the next accepted `start`, which clears both within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin the erase sequence |
| mem_addr | output | AW | Array address |
| mem_wdata | output | DW | Program data, 0x00 during program pulses |
| mem_rdata | input | DW | Read data, valid in the same cycle as the address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program/erase strobe, active low |
| hv_addr_en | output | 1 | High-voltage flag for the erase address line |
| hv_supply_en | output | 1 | High-voltage flag for the program supply |
| done | output | 1 | One-cycle completion strobe |
| pass | output | 1 | Erase succeeded, held until next start |
| fail | output | 1 | Attempt limit reached, held until next start |

## Verification
The bench builds the sequencer with AW=3 (eight bytes), PROG_CYC=3, ERASE_CYC=6, SETUP_CYC=4 and MAX_TRIES=4. This keeps each run under two hundred cycles. With these values, runs are within reach that pass on the first, second, third and fourth (last allowed) pulse, and a run that exhausts the limit. The array model gives each byte its own count of pulses needed to erase. A byte that lags in the middle of the array therefore shows where a verify pass stops.

// File: rtl/ces_pkg.sv
// Shared types for the whole-array erase sequencer.
package ces_pkg;

    // Sequencer phases, in the order a normal run visits them.
    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_PRG_PULSE = 3'd1,
        S_PRG_GAP   = 3'd2,
        S_ERASE     = 3'd3,
        S_SETTLE    = 3'd4,
        S_VERIFY    = 3'd5,
        S_DONE      = 3'd6
    } ces_state_e;

    // Drive levels for the memory control port in one phase.
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic pgm_n;
        logic hv_addr;
        logic hv_supply;
    } ces_ctrl_t;

endpackage

// File: rtl/ces_timer.sv
// Phase duration timer.
// A load writes the remaining count, and the timer then counts down to zero
// and stays there. zero is high in the final cycle of a phase that was
// loaded with (length - 1).
// Assumes: load has priority over counting.
module ces_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_q;

    // Load or count down, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/ces_addr_walker.sv
// Address walker for the program and verify passes.
// It steps through 0 .. 2**AW-1 and flags the final location.
// Assumes: the caller never increments past the last address.
module ces_addr_walker #(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

    logic [AW-1:0] addr_q;

    // Return to zero on clear, otherwise step by one on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr_q <= '0;
        end else if (inc) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = (addr_q == LAST_ADDR);
endmodule

// File: rtl/ces_try_counter.sv
// Counts the erase pulses applied in the current run.
// at_limit rises once MAX_TRIES pulses have been issued.
// Assumes: inc is never asked for when at_limit is already high.
module ces_try_counter #(
    parameter int MAX_TRIES = 200,
    parameter int CW        = $clog2(MAX_TRIES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count,
    output logic          at_limit
);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_TRIES);

    logic [CW-1:0] cnt_q;

    // Clear at the start of a run, then count each erase pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count    = cnt_q;
    assign at_limit = (cnt_q == LIMIT);
endmodule

// File: rtl/chip_erase_seq.sv
// Whole-array erase sequencer.
// It programs every byte to zero, then alternates a chip erase pulse and
// a settle delay with a read-back of the whole array that expects all ones.
// The loop retries up to MAX_TRIES pulses.
// Assumes: mem_rdata is valid in the same cycle as mem_addr while the output
// is enabled, and the external supplies follow the high-voltage flags.
module chip_erase_seq
    import ces_pkg::*;
#(
    parameter int AW        = 17,
    parameter int DW        = 8,
    parameter int PROG_CYC  = 2500,
    parameter int ERASE_CYC = 50000000,
    parameter int SETUP_CYC = 50000000,
    parameter int MAX_TRIES = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_pgm_n,
    output logic          hv_addr_en,
    output logic          hv_supply_en,
    output logic          done,
    output logic          pass,
    output logic          fail
);
    localparam int MAX_DUR = (ERASE_CYC > SETUP_CYC)
                           ? ((ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC)
                           : ((SETUP_CYC > PROG_CYC) ? SETUP_CYC : PROG_CYC);
    localparam int TW = $clog2(MAX_DUR + 1);
    localparam int CW = $clog2(MAX_TRIES + 1);
    localparam logic [TW-1:0] PROG_LD  = TW'(PROG_CYC - 1);
    localparam logic [TW-1:0] ERASE_LD = TW'(ERASE_CYC - 1);
    localparam logic [TW-1:0] SETUP_LD = TW'(SETUP_CYC - 1);

    ces_state_e    state_q, state_d;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          addr_clr, addr_inc, addr_last;
    logic          try_clr, try_inc, try_at_limit;
    logic [CW-1:0] try_count;
    logic          set_pass, set_fail, clr_result;
    logic          pass_q, fail_q;
    logic          byte_erased;
    ces_ctrl_t     ctrl;
    logic [DW-1:0] bit_one;

    ces_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    ces_addr_walker #(.AW(AW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (addr_clr),
        .inc   (addr_inc),
        .addr  (mem_addr),
        .last  (addr_last)
    );

    ces_try_counter #(.MAX_TRIES(MAX_TRIES), .CW(CW)) u_tries (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (try_clr),
        .inc      (try_inc),
        .count    (try_count),
        .at_limit (try_at_limit)
    );

    // Per-bit erased test on the read data, one lane per data bit.
    for (genvar b = 0; b < DW; b++) begin : g_lane
        assign bit_one[b] = mem_rdata[b];
    end
    assign byte_erased = &bit_one;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result levels: cleared by an accepted start, set when the run ends.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_result) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (set_pass) pass_q <= 1'b1;
            if (set_fail) fail_q <= 1'b1;
        end
    end

    // Next phase and the strobes to the timer, walker and attempt counter.
    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = PROG_LD;
        addr_clr   = 1'b0;
        addr_inc   = 1'b0;
        try_clr    = 1'b0;
        try_inc    = 1'b0;
        set_pass   = 1'b0;
        set_fail   = 1'b0;
        clr_result = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d    = S_PRG_PULSE;
                    addr_clr   = 1'b1;
                    try_clr    = 1'b1;
                    clr_result = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = PROG_LD;
                end
            end
            S_PRG_PULSE: begin
                if (tmr_zero) state_d = S_PRG_GAP;
            end
            S_PRG_GAP: begin
                tmr_load = 1'b1;
                if (addr_last) begin
                    state_d = S_ERASE;
                    tmr_val = ERASE_LD;
                    try_inc = 1'b1;
                end else begin
                    state_d  = S_PRG_PULSE;
                    tmr_val  = PROG_LD;
                    addr_inc = 1'b1;
                end
            end
            S_ERASE: begin
                if (tmr_zero) begin
                    state_d  = S_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_LD;
                    addr_clr = 1'b1;
                end
            end
            S_SETTLE: begin
                if (tmr_zero) state_d = S_VERIFY;
            end
            S_VERIFY: begin
                if (!byte_erased) begin
                    if (try_at_limit) begin
                        state_d  = S_DONE;
                        set_fail = 1'b1;
                    end else begin
                        state_d  = S_ERASE;
                        tmr_load = 1'b1;
                        tmr_val  = ERASE_LD;
                        try_inc  = 1'b1;
                    end
                end else if (addr_last) begin
                    state_d  = S_DONE;
                    set_pass = 1'b1;
                end else begin
                    addr_inc = 1'b1;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // Memory control levels for each phase.
    always_comb begin
        ctrl = '{ce_n: 1'b1, oe_n: 1'b1, pgm_n: 1'b1, hv_addr: 1'b0, hv_supply: 1'b0};
        unique case (state_q)
            S_PRG_PULSE: ctrl = '{ce_n: 1'b0, oe_n: 1'b1, pgm_n: 1'b0, hv_addr: 1'b0, hv_supply: 1'b1};
            S_PRG_GAP:   ctrl = '{ce_n: 1'b0, oe_n: 1'b1, pgm_n: 1'b1, hv_addr: 1'b0, hv_supply: 1'b1};
            S_ERASE:     ctrl = '{ce_n: 1'b0, oe_n: 1'b1, pgm_n: 1'b0, hv_addr: 1'b1, hv_supply: 1'b1};
            S_SETTLE:    ctrl = '{ce_n: 1'b0, oe_n: 1'b1, pgm_n: 1'b1, hv_addr: 1'b0, hv_supply: 1'b1};
            S_VERIFY:    ctrl = '{ce_n: 1'b0, oe_n: 1'b0, pgm_n: 1'b1, hv_addr: 1'b0, hv_supply: 1'b1};
            default:     ctrl = '{ce_n: 1'b1, oe_n: 1'b1, pgm_n: 1'b1, hv_addr: 1'b0, hv_supply: 1'b0};
        endcase
    end

    assign mem_ce_n     = ctrl.ce_n;
    assign mem_oe_n     = ctrl.oe_n;
    assign mem_pgm_n    = ctrl.pgm_n;
    assign hv_addr_en   = ctrl.hv_addr;
    assign hv_supply_en = ctrl.hv_supply;
    assign mem_wdata    = (state_q == S_PRG_PULSE) ? '0 : '1;
    assign done         = (state_q == S_DONE);
    assign pass         = pass_q;
    assign fail         = fail_q;

    // The attempt count is consumed only through at_limit.
    logic unused_ok;
    assign unused_ok = ^try_count;
endmodule

// File: rtl/chip_erase_seq_chk.sv
// Protocol checker for the erase sequencer, bound to its top module.
// Assumes: the ports are observed at the sequencer boundary only.
module chip_erase_seq_chk #(
    parameter int ERASE_CYC = 6,
    parameter int SETUP_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic mem_ce_n,
    input logic mem_oe_n,
    input logic mem_pgm_n,
    input logic hv_addr_en,
    input logic hv_supply_en,
    input logic done,
    input logic pass,
    input logic fail
);
    int unsigned hv_cnt;
    int unsigned since_erase;
    logic        armed;

    // Length of the current high-voltage address pulse so far.
    always_ff @(posedge clk) begin
        if (!rst_n) hv_cnt <= 0;
        else        hv_cnt <= hv_addr_en ? hv_cnt + 1 : 0;
    end

    // Cycles since the last erase pulse, and whether a read is still awaited.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_erase <= 0;
            armed       <= 1'b0;
        end else begin
            if (hv_addr_en)                     since_erase <= 0;
            else if (since_erase < 32'hFFFF_0000) since_erase <= since_erase + 1;
            if (hv_addr_en)     armed <= 1'b1;
            else if (!mem_oe_n) armed <= 1'b0;
        end
    end

    AST_HV_ADDR_WITH_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        hv_addr_en |-> (hv_supply_en && !mem_pgm_n && !mem_ce_n && mem_oe_n)); // R3
    AST_ERASE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hv_addr_en) |-> ($past(hv_cnt) == ERASE_CYC - 1)); // R3
    AST_ERASE_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        hv_addr_en |-> (hv_cnt < ERASE_CYC)); // R3
    AST_SETTLE_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && armed) |-> (since_erase >= SETUP_CYC)); // R4
    AST_READ_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_pgm_n && !hv_addr_en && !mem_ce_n)); // R5
    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail)); // R7
    AST_DONE_HAS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass || fail)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done) |-> ($stable(pass) && $stable(fail))); // R10
endmodule

bind chip_erase_seq chip_erase_seq_chk #(
    .ERASE_CYC (ERASE_CYC),
    .SETUP_CYC (SETUP_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_ce_n     (mem_ce_n),
    .mem_oe_n     (mem_oe_n),
    .mem_pgm_n    (mem_pgm_n),
    .hv_addr_en   (hv_addr_en),
    .hv_supply_en (hv_supply_en),
    .done         (done),
    .pass         (pass),
    .fail         (fail)
);

// File: tb/chip_erase_seq_tb.sv
// Scoreboard bench: the driver queues the expected result of each run, and
// the monitor checks the port protocol and compares each completion.
module chip_erase_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int NB = 1 << AW;
    localparam int PROG_CYC  = 3;
    localparam int ERASE_CYC = 6;
    localparam int SETUP_CYC = 4;
    localparam int MAX_TRIES = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_ce_n, mem_oe_n, mem_pgm_n;
    logic          hv_addr_en, hv_supply_en;
    logic          done, pass, fail;

    int checks = 0;
    int errors = 0;
    int runs_seen = 0;
    bit finished = 1'b0;

    typedef struct {
        bit exp_pass;
        int exp_pulses;
        int exp_first_reads;
    } exp_t;
    exp_t sb_q[$];

    // Array model state.
    logic [DW-1:0] mem [NB];
    int            need [NB];
    logic          load_mem = 1'b0;
    logic          hv_prev;
    int            model_pulses;

    always #(CLK_PERIOD/2) clk = ~clk;

    chip_erase_seq #(
        .AW(AW), .DW(DW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
        .SETUP_CYC(SETUP_CYC), .MAX_TRIES(MAX_TRIES)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
        .hv_addr_en(hv_addr_en), .hv_supply_en(hv_supply_en),
        .done(done), .pass(pass), .fail(fail)
    );

    assign mem_rdata = mem[mem_addr];

    // Array model: fill on request, AND-in program data, erase per-byte need.
    always @(posedge clk) begin
        hv_prev <= hv_addr_en;
        if (load_mem) begin
            for (int i = 0; i < NB; i++) mem[i] <= 8'h5A ^ 8'(i * 37);
            model_pulses <= 0;
        end else begin
            if (!mem_ce_n && !mem_pgm_n && hv_supply_en && !hv_addr_en)
                mem[mem_addr] <= mem[mem_addr] & mem_wdata;
            if (hv_prev && !hv_addr_en) begin
                model_pulses <= model_pulses + 1;
                for (int i = 0; i < NB; i++)
                    if (model_pulses + 1 >= need[i]) mem[i] <= '1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor state.
    int  pulses = 0, hv_len = 0, gap = 0, exp_addr = 0, first_reads = 0;
    bit  gap_armed = 0, after_done = 0, held_pass = 0;

    // Monitor: protocol checks every cycle, scoreboard compare on done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (after_done) begin
                after_done = 0;
                check(done == 1'b0, "R10", "done width", done, 0);
                check(pass == held_pass, "R10", "pass held", pass, held_pass);
                pulses = 0; first_reads = 0; exp_addr = 0; gap_armed = 0;
            end
            if (!mem_pgm_n && !hv_addr_en) begin
                check(mem_oe_n && !mem_ce_n && hv_supply_en, "R2", "program levels", 0, 1);
                check(mem_wdata == 8'h00, "R2", "program data", mem_wdata, 0);
                check(pulses == 0, "R2", "program after erase", pulses, 0);
            end
            if (hv_addr_en) begin
                if (hv_len == 0) begin
                    pulses++;
                    exp_addr = 0;
                    if (pulses == 1) begin
                        bit all_zero = 1;
                        for (int i = 0; i < NB; i++) if (mem[i] != 0) all_zero = 0;
                        check(all_zero, "R2", "array zero before erase", all_zero, 1);
                    end
                end
                hv_len++;
                gap = 0;
                gap_armed = 1;
                check(hv_supply_en && !mem_pgm_n && !mem_ce_n && mem_oe_n,
                      "R3", "erase levels", 0, 1);
            end else begin
                if (hv_len != 0)
                    check(hv_len == ERASE_CYC, "R3", "erase length", hv_len, ERASE_CYC);
                hv_len = 0;
                if (gap_armed) begin
                    if (!mem_oe_n) begin
                        check(gap >= SETUP_CYC, "R4", "settle cycles", gap, SETUP_CYC);
                        gap_armed = 0;
                    end else gap++;
                end
            end
            if (!mem_oe_n) begin
                check(mem_pgm_n && !hv_addr_en && !mem_ce_n, "R5", "read levels", 0, 1);
                check(int'(mem_addr) == exp_addr, "R5", "read address", mem_addr, exp_addr);
                exp_addr++;
                if (pulses == 1) first_reads++;
            end
            if (done) begin
                exp_t e;
                if (sb_q.size() == 0) begin
                    check(0, "R7", "unexpected done", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    check(pass == e.exp_pass, e.exp_pass ? "R7" : "R8", "pass", pass, e.exp_pass);
                    check(fail == !e.exp_pass, e.exp_pass ? "R7" : "R8", "fail", fail, !e.exp_pass);
                    check(pulses == e.exp_pulses, e.exp_pass ? "R7" : "R8",
                          "erase pulses", pulses, e.exp_pulses);
                    check(first_reads == e.exp_first_reads, "R6",
                          "reads in first verify", first_reads, e.exp_first_reads);
                end
                held_pass = pass;
                after_done = 1;
                runs_seen++;
            end
        end
    end

    // Driver: set per-byte erase needs, queue the expectation, start, wait.
    task automatic run_case(input int base_need, input int odd_idx, input int odd_need,
                            input bit exp_pass, input int exp_pulses,
                            input int exp_first, input bit busy_start);
        int target = runs_seen + 1;
        for (int i = 0; i < NB; i++) need[i] = (i == odd_idx) ? odd_need : base_need;
        sb_q.push_back('{exp_pass, exp_pulses, exp_first});
        @(negedge clk); load_mem = 1'b1;
        @(negedge clk); load_mem = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        check(!pass && !fail, "R10", "result cleared by start", pass, 0);
        if (busy_start) begin
            while (!hv_addr_en) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            check(!done && !pass && !fail, "R9", "start while busy", done, 0);
        end
        while (runs_seen < target) @(negedge clk);
        repeat (4) @(negedge clk);
        check(pass == exp_pass, "R10", "pass held after done", pass, exp_pass);
        check(fail == !exp_pass, "R10", "fail held after done", fail, !exp_pass);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) need[i] = 1;
        repeat (3) @(negedge clk);
        // R1: reset levels
        check(mem_ce_n && mem_oe_n && mem_pgm_n, "R1", "strobes in reset", 0, 1);
        check(!hv_addr_en && !hv_supply_en, "R1", "hv flags in reset", 0, 1);
        check(!done && !pass && !fail, "R1", "status in reset", 0, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_ce_n && !hv_supply_en && !done, "R1", "idle after reset", 0, 1);
        // R7: erased by the first pulse
        run_case(1, 0, 1, 1'b1, 1, NB, 1'b0);
        // R6: all bytes need three pulses, each failed verify stops at address 0; R9 start mid-run
        run_case(3, 0, 3, 1'b1, 3, 1, 1'b1);
        // R6: byte 5 lags by one pulse, first verify stops after six reads
        run_case(1, 5, 2, 1'b1, 2, 6, 1'b0);
        // R8: byte 7 never erases, limit of four pulses reached
        run_case(1, NB - 1, 99, 1'b0, MAX_TRIES, NB, 1'b0);
        // R7: success on exactly the last allowed pulse
        run_case(MAX_TRIES, 0, MAX_TRIES, 1'b1, MAX_TRIES, 1, 1'b0);
        check(sb_q.size() == 0, "R7", "scoreboard drained", sb_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual %0d expected %0d", runs_seen, 5);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule